// File: doc/BRIEF.md
# Parallel Mixed-Length Instruction Splitter

This block takes a fetch window made of 16-bit halfwords and, in one clock cycle, marks where every instruction in it begins. Each instruction is either one halfword or two halfwords long. The length is read from the two lowest bits of the instruction's first halfword, and no other bit is inspected. The walk begins at a caller-supplied halfword index. The block then packs the instructions it found into a row of output slots, in program order.

The number of slots filled per cycle is limited twice. The first limit is the slot count fixed at build time. The second is a per-request limit, which can be lower. Instructions beyond those limits stay in the window. The caller moves its fetch pointer by the reported consumed byte count and presents the remainder on a later request. A 32-bit instruction that begins on the window's last halfword cannot be complete, so it is reported as a trailing partial instead of being emitted. Requests are accepted through a valid/ready pair, and all results are registered.

Top module: `msplit_splitter`

## Requirements
- R1: A halfword whose bits [1:0] are 2'b11 starts a 32-bit instruction. Any other value of those two bits starts a 16-bit instruction. `slot_is32` of each filled slot reports this length.
- R2: The first instruction begins at halfword index `start_hw`. Each following instruction begins directly after the previous one ends. Halfwords below `start_hw` have no effect. A slot's byte offset is twice the halfword index of the instruction's first halfword.
- R3: Filled slots are packed from slot 0 in program order, with no gaps. `slot_valid` is therefore always a contiguous mask starting at bit 0.
- R4: A 16-bit instruction appears in bits [15:0] of its 32-bit slot field, with bits [31:16] zero. A 32-bit instruction has its first halfword in bits [15:0] and its second halfword in bits [31:16].
- R5: The number of filled slots is the smallest of three values: the number of complete instructions, `slot_limit`, and MAX_SLOTS. A `slot_limit` above MAX_SLOTS acts as MAX_SLOTS. A `slot_limit` of 0 fills no slot.
- R6: `consumed_bytes` equals the sum of the lengths of the filled slots: 2 for each 16-bit slot and 4 for each 32-bit slot.
- R7: A 32-bit instruction that starts on the last halfword of the window is never placed in a slot. `tail_partial` is 1 exactly when such an instruction is present and every complete instruction before it was emitted. In that case `consumed_bytes` ends right at its first byte.
- R8: `in_ready` equals `out_ready`. When `in_valid` and `out_ready` are both high at a rising edge, the results for that request appear after the edge and `out_valid` becomes 1. When `out_ready` is high and `in_valid` is low, `out_valid` becomes 0 and the result fields hold. While `out_ready` is low, every output holds.
- R9: After a synchronous active-low reset, `out_valid`, `slot_valid`, `consumed_bytes` and `tail_partial` read 0.
- R10: In every unfilled slot, the instruction, length and offset fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | A request can be accepted |
| win_data | input | WIN_BYTES*8 | Fetch window; halfword i occupies bits [16i+15:16i] |
| start_hw | input | log2(WIN_BYTES/2) | Halfword index of the first instruction |
| slot_limit | input | log2(MAX_SLOTS+1) | Per-request cap on filled slots |
| out_valid | output | 1 | Registered results are valid |
| out_ready | input | 1 | Downstream accepts results |
| slot_valid | output | MAX_SLOTS | Filled-slot mask |
| slot_insn | output | MAX_SLOTS*32 | Instruction bits; slot k occupies [32k+31:32k] |
| slot_is32 | output | MAX_SLOTS | Per-slot 32-bit length flag |
| slot_offset | output | MAX_SLOTS*log2(WIN_BYTES) | Per-slot byte offset in the window |
| consumed_bytes | output | log2(WIN_BYTES+1) | Bytes taken by the filled slots |
| tail_partial | output | 1 | A trailing 32-bit instruction is cut off by the window end |

## Verification
Each request is computed from scratch, so a fault in the boundary chain or in the slot ranking shows up on the very next accepted result. A broken chain link misplaces every instruction after it: offsets shift, a 32-bit slot shows the wrong halfword pair, and `consumed_bytes` moves by a multiple of two. A ranking fault instead leaves a hole in `slot_valid` or a filled slot past the limit. Faults in the hold logic only show while `out_ready` is low, so the bench stalls the output with a different request waiting and checks that nothing moves.

// File: rtl/msplit_pkg.sv
// Package: msplit_pkg
// Shared constants and helpers for the instruction splitter.
// Assumes instructions are built from 16-bit halfwords.
package msplit_pkg;

    localparam int HW_BITS = 16;

    // True when a halfword opens a two-halfword instruction.
    function automatic logic is_long_hw(input logic [HW_BITS-1:0] hw);
        return hw[1:0] == 2'b11;
    endfunction

endpackage

// File: rtl/msplit_boundary.sv
// Module: msplit_boundary
// Marks the first halfword of every complete instruction in the window,
// walking a start chain from first_hw upward. Purely combinational.
// Assumes NHW >= 2. A long start on the last halfword is reported on
// tail_cut and is not included in head_mask.
module msplit_boundary
    import msplit_pkg::*;
#(
    parameter int NHW  = 8,
    parameter int HW_W = $clog2(NHW)
) (
    input  logic [NHW*HW_BITS-1:0] win,
    input  logic [HW_W-1:0]        first_hw,
    output logic [NHW-1:0]         head_mask,
    output logic [NHW-1:0]         long_mask,
    output logic                   tail_cut
);

    // Length class of every halfword position.
    always_comb begin : p_len
        for (int i = 0; i < NHW; i++) begin
            long_mask[i] = is_long_hw(win[i*HW_BITS +: HW_BITS]);
        end
    end

    // Start chain, with two zero guard positions below index 0.
    always_comb begin : p_chain
        logic [NHW+1:0] hx;
        logic [NHW+1:0] lx;
        hx = '0;
        lx = {long_mask, 2'b00};
        for (int i = 0; i < NHW; i++) begin
            if (i == int'(first_hw)) begin
                hx[i+2] = 1'b1;
            end else if (i > int'(first_hw)) begin
                hx[i+2] = (hx[i+1] & ~lx[i+1]) | (hx[i] & lx[i]);
            end
        end
        head_mask          = hx[NHW+1:2];
        head_mask[NHW-1]   = hx[NHW+1] & ~long_mask[NHW-1];
        tail_cut           = hx[NHW+1] & long_mask[NHW-1];
    end

endmodule

// File: rtl/msplit_packer.sv
// Module: msplit_packer
// Ranks instruction heads in program order and places the first cap_eff
// of them in slots 0 upward. Sums the emitted lengths. Purely
// combinational. Assumes cap_eff <= MAX_SLOTS, with MAX_SLOTS >= 2.
module msplit_packer
    import msplit_pkg::*;
#(
    parameter int NHW       = 8,
    parameter int MAX_SLOTS = 6,
    parameter int CAP_W     = $clog2(MAX_SLOTS + 1),
    parameter int OFF_W     = $clog2(NHW * 2),
    parameter int CONS_W    = $clog2(NHW * 2 + 1)
) (
    input  logic [NHW*HW_BITS-1:0]          win,
    input  logic [NHW-1:0]                  head_mask,
    input  logic [NHW-1:0]                  long_mask,
    input  logic [CAP_W-1:0]                cap_eff,
    output logic [MAX_SLOTS-1:0]            slot_vld,
    output logic [MAX_SLOTS-1:0][31:0]      slot_insn,
    output logic [MAX_SLOTS-1:0]            slot_long,
    output logic [MAX_SLOTS-1:0][OFF_W-1:0] slot_off,
    output logic [CONS_W-1:0]               used_bytes,
    output logic                            all_fit
);

    localparam int SLOT_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

    // Walk the heads in order and fill slots up to the cap.
    always_comb begin : p_pack
        logic [NHW*HW_BITS+HW_BITS-1:0] wx;
        int                             rank;
        logic [SLOT_W-1:0]              idx;
        wx         = {{HW_BITS{1'b0}}, win};
        rank       = 0;
        idx        = '0;
        slot_vld   = '0;
        slot_insn  = '0;
        slot_long  = '0;
        slot_off   = '0;
        used_bytes = '0;
        for (int i = 0; i < NHW; i++) begin
            if (head_mask[i]) begin
                if (rank < int'(cap_eff)) begin
                    idx            = SLOT_W'(rank);
                    slot_vld[idx]  = 1'b1;
                    slot_long[idx] = long_mask[i];
                    slot_off[idx]  = OFF_W'(2 * i);
                    if (long_mask[i]) begin
                        slot_insn[idx] = wx[i*HW_BITS +: 32];
                        used_bytes     = used_bytes + CONS_W'(4);
                    end else begin
                        slot_insn[idx] = {16'h0000, wx[i*HW_BITS +: HW_BITS]};
                        used_bytes     = used_bytes + CONS_W'(2);
                    end
                end
                rank = rank + 1;
            end
        end
        all_fit = (rank <= int'(cap_eff));
    end

endmodule

// File: rtl/msplit_splitter.sv
// Module: msplit_splitter
// Top of the parallel mixed-length splitter. It finds every 16/32-bit
// instruction in a fetch window in one cycle, caps how many it emits,
// and registers the packed slots behind a valid/ready pair.
// Assumes WIN_BYTES is 16, 32 or 64 and MAX_SLOTS >= 2.
module msplit_splitter
    import msplit_pkg::*;
#(
    parameter  int WIN_BYTES = 16,
    parameter  int MAX_SLOTS = 6,
    localparam int NHW       = WIN_BYTES / 2,
    localparam int HW_W      = $clog2(NHW),
    localparam int CAP_W     = $clog2(MAX_SLOTS + 1),
    localparam int OFF_W     = $clog2(WIN_BYTES),
    localparam int CONS_W    = $clog2(WIN_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [WIN_BYTES*8-1:0]     win_data,
    input  logic [HW_W-1:0]            start_hw,
    input  logic [CAP_W-1:0]           slot_limit,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [MAX_SLOTS-1:0]       slot_valid,
    output logic [MAX_SLOTS*32-1:0]    slot_insn,
    output logic [MAX_SLOTS-1:0]       slot_is32,
    output logic [MAX_SLOTS*OFF_W-1:0] slot_offset,
    output logic [CONS_W-1:0]          consumed_bytes,
    output logic                       tail_partial
);

    logic [NHW-1:0]                  head_mask;
    logic [NHW-1:0]                  long_mask;
    logic                            tail_cut;
    logic [CAP_W-1:0]                cap_eff;
    logic [MAX_SLOTS-1:0]            pk_vld;
    logic [MAX_SLOTS-1:0][31:0]      pk_insn;
    logic [MAX_SLOTS-1:0]            pk_long;
    logic [MAX_SLOTS-1:0][OFF_W-1:0] pk_off;
    logic [CONS_W-1:0]               pk_used;
    logic                            pk_fit;
    logic [MAX_SLOTS*32-1:0]         nx_insn;
    logic [MAX_SLOTS*OFF_W-1:0]      nx_off;
    logic                            take;

    msplit_boundary #(
        .NHW  (NHW),
        .HW_W (HW_W)
    ) u_boundary (
        .win       (win_data),
        .first_hw  (start_hw),
        .head_mask (head_mask),
        .long_mask (long_mask),
        .tail_cut  (tail_cut)
    );

    // Clamp the request's slot limit to the built slot count.
    always_comb begin : p_cap
        cap_eff = (slot_limit > CAP_W'(MAX_SLOTS)) ? CAP_W'(MAX_SLOTS) : slot_limit;
    end

    msplit_packer #(
        .NHW       (NHW),
        .MAX_SLOTS (MAX_SLOTS),
        .CAP_W     (CAP_W),
        .OFF_W     (OFF_W),
        .CONS_W    (CONS_W)
    ) u_packer (
        .win        (win_data),
        .head_mask  (head_mask),
        .long_mask  (long_mask),
        .cap_eff    (cap_eff),
        .slot_vld   (pk_vld),
        .slot_insn  (pk_insn),
        .slot_long  (pk_long),
        .slot_off   (pk_off),
        .used_bytes (pk_used),
        .all_fit    (pk_fit)
    );

    // Flatten the slot arrays onto the port layout.
    for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_flat
        assign nx_insn[k*32 +: 32]      = pk_insn[k];
        assign nx_off[k*OFF_W +: OFF_W] = pk_off[k];
    end

    assign in_ready = out_ready;
    assign take     = in_valid & out_ready;

    // Output register: load on an accepted request, hold otherwise.
    always_ff @(posedge clk) begin : p_out
        if (!rst_n) begin
            out_valid      <= 1'b0;
            slot_valid     <= '0;
            slot_insn      <= '0;
            slot_is32      <= '0;
            slot_offset    <= '0;
            consumed_bytes <= '0;
            tail_partial   <= 1'b0;
        end else if (out_ready) begin
            out_valid <= in_valid;
            if (take) begin
                slot_valid     <= pk_vld;
                slot_insn      <= nx_insn;
                slot_is32      <= pk_long;
                slot_offset    <= nx_off;
                consumed_bytes <= pk_used;
                tail_partial   <= tail_cut & pk_fit;
            end
        end
    end

    // Slot 0 of a live request sits at the requested start.
    AST_FIRST_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pk_vld[0]) |-> (pk_off[0] == OFF_W'({start_hw, 1'b0}))); // R2

    // Never more filled slots than the clamped limit.
    AST_CAP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ($countones(pk_vld) <= int'(cap_eff))); // R5

    // Registered valid mask is a low-order run of ones.
    AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((slot_valid & MAX_SLOTS'(slot_valid + 1'b1)) == '0)); // R3

    // A reported partial means consumption stops just before the last halfword.
    AST_PARTIAL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && tail_cut && pk_fit) |->
        (int'(pk_used) + 2 * int'(start_hw) == WIN_BYTES - 2)); // R7

    // A stalled output does not move.
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> ($stable(out_valid) && $stable(slot_valid) && $stable(consumed_bytes)
                        && $stable(tail_partial))); // R8

    for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_slot_chk
        // The length flag agrees with the low bits of the slot's instruction.
        AST_LEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[k] |-> (slot_is32[k] == (slot_insn[k*32 +: 2] == 2'b11))); // R1
        // Unfilled slots carry zeros.
        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_valid[k] |-> ((slot_insn[k*32 +: 32] == '0) && !slot_is32[k]
                                && (slot_offset[k*OFF_W +: OFF_W] == '0))); // R10
    end

endmodule

// File: tb/msplit_splitter_bench.sv
`timescale 1ns/1ps
// Bench for msplit_splitter: directed corners plus seeded random windows,
// checked against a sequential halfword walk.
module msplit_splitter_bench;

    localparam int WB     = 16;
    localparam int MS     = 6;
    localparam int NHW    = WB / 2;
    localparam int HW_W   = $clog2(NHW);
    localparam int CAP_W  = $clog2(MS + 1);
    localparam int OFF_W  = $clog2(WB);
    localparam int CONS_W = $clog2(WB + 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic                  in_ready;
    logic [WB*8-1:0]       win_data = '0;
    logic [HW_W-1:0]       start_hw = '0;
    logic [CAP_W-1:0]      slot_limit = '0;
    logic                  out_valid;
    logic                  out_ready = 1'b1;
    logic [MS-1:0]         slot_valid;
    logic [MS*32-1:0]      slot_insn;
    logic [MS-1:0]         slot_is32;
    logic [MS*OFF_W-1:0]   slot_offset;
    logic [CONS_W-1:0]     consumed_bytes;
    logic                  tail_partial;

    logic [MS-1:0]         e_vld;
    logic [MS*32-1:0]      e_insn;
    logic [MS-1:0]         e_l;
    logic [MS*OFF_W-1:0]   e_off;
    logic [CONS_W-1:0]     e_cons;
    logic                  e_part;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    msplit_splitter #(.WIN_BYTES(WB), .MAX_SLOTS(MS)) u_msplit_splitter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .win_data(win_data), .start_hw(start_hw), .slot_limit(slot_limit),
        .out_valid(out_valid), .out_ready(out_ready), .slot_valid(slot_valid),
        .slot_insn(slot_insn), .slot_is32(slot_is32), .slot_offset(slot_offset),
        .consumed_bytes(consumed_bytes), .tail_partial(tail_partial)
    );

    task automatic chk(input string req, input string what, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Sequential reference: walk halfword by halfword from the start.
    task automatic model(input logic [WB*8-1:0] w, input int st, input int lim);
        int p;
        int r;
        int eff;
        logic lg;
        e_vld = '0; e_insn = '0; e_l = '0; e_off = '0; e_cons = '0; e_part = 1'b0;
        eff = (lim > MS) ? MS : lim;
        p = st;
        r = 0;
        while (p < NHW) begin
            lg = (w[p*16 +: 2] == 2'b11);
            if (lg && p == NHW - 1) begin
                e_part = (r <= eff);
                break;
            end
            if (r < eff) begin
                e_vld[r] = 1'b1;
                e_l[r] = lg;
                e_off[r*OFF_W +: OFF_W] = OFF_W'(2 * p);
                e_insn[r*32 +: 32] = lg ? w[p*16 +: 32] : {16'h0000, w[p*16 +: 16]};
                e_cons = e_cons + CONS_W'(lg ? 4 : 2);
            end
            r++;
            p += lg ? 2 : 1;
        end
    endtask

    task automatic compare(input logic exp_ov);
        chk("R8", "out_valid", 256'(out_valid), 256'(exp_ov));
        chk("R8", "in_ready", 256'(in_ready), 256'(out_ready));
        chk("R3 R5", "slot_valid", 256'(slot_valid), 256'(e_vld));
        chk("R4 R10", "slot_insn", 256'(slot_insn), 256'(e_insn));
        chk("R1", "slot_is32", 256'(slot_is32), 256'(e_l));
        chk("R2", "slot_offset", 256'(slot_offset), 256'(e_off));
        chk("R6", "consumed_bytes", 256'(consumed_bytes), 256'(e_cons));
        chk("R7", "tail_partial", 256'(tail_partial), 256'(e_part));
    endtask

    // Drive one request at a falling edge and check it one edge later.
    task automatic apply(input logic [WB*8-1:0] w, input int st, input int lim);
        win_data = w;
        start_hw = HW_W'(st);
        slot_limit = CAP_W'(lim);
        in_valid = 1'b1;
        model(w, st, lim);
        @(negedge clk);
        compare(1'b1);
    endtask

    function automatic logic [WB*8-1:0] fill(input logic [1:0] low);
        logic [WB*8-1:0] w;
        for (int i = 0; i < NHW; i++) w[i*16 +: 16] = {8'(i + 1), 6'h05, low};
        return w;
    endfunction

    function automatic logic [WB*8-1:0] rnd_win();
        logic [WB*8-1:0] w;
        for (int i = 0; i < NHW; i++) begin
            w[i*16 +: 16] = 16'($urandom);
            if ($urandom % 3 == 0) w[i*16 +: 2] = 2'b11;
        end
        return w;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [WB*8-1:0] w;
        void'($urandom(32'h1A2B));
        repeat (3) @(negedge clk);
        // R9: reset state.
        model('0, 0, 0);
        compare(1'b0);
        rst_n = 1'b1;

        // R5: all 16-bit, more instructions than slots.
        apply(fill(2'b00), 0, 7);
        // R1 R2 R4: all 32-bit from halfword 0.
        apply(fill(2'b11), 0, 6);
        // R7: a lone 32-bit start on the last halfword.
        apply(fill(2'b11), NHW - 1, 6);
        // R2: a 16-bit start on the last halfword.
        apply(fill(2'b10), NHW - 1, 3);
        // R5: limit 0 with a trailing partial, so no partial is reported.
        w = fill(2'b01);
        w[(NHW-1)*16 +: 2] = 2'b11;
        apply(w, NHW - 2, 0);
        // R7: same window, limit large enough.
        apply(w, NHW - 2, 1);
        // R2: halfwords below the start are ignored.
        w = fill(2'b11);
        w[0 +: 16] = 16'hFFFF;
        apply(w, 1, 7);

        // R8: stall with a different request waiting; outputs hold.
        out_ready = 1'b0;
        win_data = fill(2'b00);
        start_hw = '0;
        slot_limit = CAP_W'(2);
        @(negedge clk);
        @(negedge clk);
        compare(1'b1);
        out_ready = 1'b1;
        model(fill(2'b00), 0, 2);
        @(negedge clk);
        compare(1'b1);
        // R8: idle request drops out_valid and holds the fields.
        in_valid = 1'b0;
        @(negedge clk);
        compare(1'b0);

        // Random windows, random starts, every limit value.
        for (int n = 0; n < 4000; n++) begin
            apply(rnd_win(), int'($urandom % NHW), n % (1 << CAP_W));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule